// File: doc/BRIEF.md
# EDH Error Flag Processor

This block builds the outgoing error-detection-and-handling status for a digital video link once per field. It combines the flags decoded from the incoming error packet with the local CRC and ancillary-checksum results. It recodes upstream reports, applies the host's per-flag overrides and latches the fifteen outgoing flags at a field-end strobe. From those flags it also drives a two-wire flag display, an active-low interrupt and an errored-field counter.

Packet parsing, packet insertion and CRC arithmetic are handled elsewhere. The block only sees their per-field results. A small register port stands in for the host interface. Through it the host writes the local internal-error flags, the force masks, the sensitivity mask and the mode bits. It reads back the latched flags and the counter. Reads have side effects: they release the interrupt and clear sticky flags or the counter.

Top module: `edhFlagProc`

## Requirements
- R1: Flag vectors (inFlags, outFlags, register masks) use bit index class*5+kind, with class 0 active picture, 1 full field, 2 ancillary, and kind 0 EDH, 1 EDA, 2 IDH, 3 IDA, 4 UES. For active picture and full field, the outgoing EDH is the local CRC mismatch. The outgoing EDA is incoming EDA OR (incoming EDH AND that class's incoming CRC-valid bit).
- R2: Ancillary EDH is the local checksum mismatch. Ancillary EDA is incoming EDH OR EDA. In every class, IDA is incoming IDH OR IDA.
- R3: When no error packet was received in the field (pktPresent=0), UES is 1 in all three classes. Active picture and full field EDH, EDA and IDA are 0. Ancillary EDA and IDA are 0, but ancillary EDH still reports a checksum mismatch.
- R4: The IDH flags come from register 0, with bit 0 for active picture, bit 1 for full field and bit 2 for ancillary.
- R5: In receive mode, each flag whose bit is set in the force mask (register 1) takes the value of its bit in the force value (register 2). Every other flag is transparent.
- R6: In transmit mode (txMode=1), all fifteen flags latch as 0 whatever the inputs, masks or sticky setting.
- R7: outFlags change only on the clock edge where fieldEnd is 1, or when a read clears sticky flags. They hold for the rest of the field.
- R8: The errored-field counter adds one at a field end if any newly computed flag that is enabled in the sensitivity mask (register 3) is set. Writing register 4 with bit 2 set clears it. With auto-clear (register 4 bit 1) on, a read of register 1 returns the count and then clears it.
- R9: The counter saturates at its all-ones value instead of wrapping.
- R10: intN goes low at a field end whose flags hit the sensitivity mask. It stays low until register 0 (the flags) is read.
- R11: After reset the flags, the counter and all control bits are 0, intN is 1, and the sensitivity mask is all ones.
- R12: dispSel picks the display pair. 0 gives full field (dispFl1=EDA, dispFl0=EDH), 1 gives active picture and 2 gives ancillary in the same way. 3 gives dispFl1 = OR of the three UES flags and dispFl0 = OR of the three IDA flags.
- R13: With sticky mode on (register 4 bit 0), a field end ORs the new flags into the held ones. A read of register 0 returns the held flags and then clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fieldEnd | input | 1 | One-cycle strobe at the end of each field |
| txMode | input | 1 | 1 = transmit (flags reset), 0 = receive |
| pktPresent | input | 1 | An error packet was received in this field |
| crcValidAp | input | 1 | Incoming active-picture CRC valid bit |
| crcValidFf | input | 1 | Incoming full-field CRC valid bit |
| crcErrAp | input | 1 | Local active-picture CRC mismatch |
| crcErrFf | input | 1 | Local full-field CRC mismatch |
| ancSumErr | input | 1 | Local ancillary checksum mismatch |
| inFlags | input | 15 | Decoded incoming flags, R1 layout |
| dispSel | input | 2 | Display pair select |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects on this edge) |
| regAddr | input | 3 | Register address |
| regWrData | input | 15 | Register write data |
| regRdData | output | max(15,CNT_W) | Read data: address 0 flags, 1 counter, else 0 |
| outFlags | output | 15 | Latched outgoing flags |
| dispFl1 | output | 1 | Display flag 1 |
| dispFl0 | output | 1 | Display flag 0 |
| intN | output | 1 | Active-low interrupt |
| errCount | output | CNT_W | Errored-field counter (default 21 bits) |

## Verification
The bench drives the EDA recoding with the CRC-valid bit both set and clear. A design that ignored the qualifier would promote an unqualified upstream EDH into EDA. A field with no packet and all input flags set checks that only UES and the ancillary checksum error survive. A design that kept stale IDA or the active-picture EDH would show extra bits. The interrupt is checked against a narrowed sensitivity mask. It must stay quiet for insensitive errors and must hold across a clean field until the flag read. Sticky accumulation, read-to-clear and auto-clear are each checked on the cycle after the read. A narrow second instance confirms that the counter stops at all ones instead of wrapping to a small value.

// File: rtl/edhFlagPkg.sv
package edhFlagPkg;
  localparam int NUM_CLASS = 3;
  localparam int NUM_KIND  = 5;
  localparam int NUM_FLAG  = NUM_CLASS * NUM_KIND;

  localparam int K_EDH = 0;
  localparam int K_EDA = 1;
  localparam int K_IDH = 2;
  localparam int K_IDA = 3;
  localparam int K_UES = 4;

  localparam int C_AP  = 0;
  localparam int C_FF  = 1;
  localparam int C_ANC = 2;

  localparam logic [2:0] ADDR_IDH   = 3'd0;
  localparam logic [2:0] ADDR_FMASK = 3'd1;
  localparam logic [2:0] ADDR_FVAL  = 3'd2;
  localparam logic [2:0] ADDR_SENS  = 3'd3;
  localparam logic [2:0] ADDR_CTRL  = 3'd4;

  localparam logic [2:0] ADDR_RD_FLAGS = 3'd0;
  localparam logic [2:0] ADDR_RD_CNT   = 3'd1;

  typedef struct packed {
    logic latch;
    logic stickyClr;
    logic cntInc;
    logic cntClr;
  } strobe_t;
endpackage

// File: rtl/edhFlagPath.sv
module edhFlagPath
  import edhFlagPkg::*;
#(
  parameter int CNT_W = 21
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic                 txMode,
  input  logic                 pktPresent,
  input  logic                 crcValidAp,
  input  logic                 crcValidFf,
  input  logic                 crcErrAp,
  input  logic                 crcErrFf,
  input  logic                 ancSumErr,
  input  logic [NUM_FLAG-1:0]  inFlags,
  input  logic [NUM_CLASS-1:0] userIdh,
  input  logic [NUM_FLAG-1:0]  forceMask,
  input  logic [NUM_FLAG-1:0]  forceVal,
  input  logic                 sticky,
  output logic [NUM_FLAG-1:0]  nextFlags,
  output logic [NUM_FLAG-1:0]  outFlags,
  output logic [CNT_W-1:0]     errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CLASS-1:0] localErr;
  logic [NUM_CLASS-1:0] crcValid;
  logic [NUM_FLAG-1:0]  rawFlags;
  logic [NUM_FLAG-1:0]  maskedFlags;

  assign localErr = {ancSumErr, crcErrFf, crcErrAp};
  assign crcValid = {1'b0, crcValidFf, crcValidAp};

  for (genvar c = 0; c < NUM_CLASS; c++) begin : gClass
    logic inEdh, inEda, inIdh, inIda, inUes;
    assign inEdh = inFlags[c*NUM_KIND + K_EDH];
    assign inEda = inFlags[c*NUM_KIND + K_EDA];
    assign inIdh = inFlags[c*NUM_KIND + K_IDH];
    assign inIda = inFlags[c*NUM_KIND + K_IDA];
    assign inUes = inFlags[c*NUM_KIND + K_UES];

    if (c == C_ANC) begin : gAnc
      // checksum errors survive a missing packet
      assign rawFlags[c*NUM_KIND + K_EDH] = localErr[c];
      assign rawFlags[c*NUM_KIND + K_EDA] = pktPresent & (inEdh | inEda);
    end else begin : gCrc
      assign rawFlags[c*NUM_KIND + K_EDH] = pktPresent & localErr[c];
      assign rawFlags[c*NUM_KIND + K_EDA] = pktPresent & (inEda | (inEdh & crcValid[c]));
    end
    assign rawFlags[c*NUM_KIND + K_IDH] = userIdh[c];
    assign rawFlags[c*NUM_KIND + K_IDA] = pktPresent & (inIdh | inIda);
    assign rawFlags[c*NUM_KIND + K_UES] = inUes | ~pktPresent;
  end

  assign maskedFlags = (rawFlags & ~forceMask) | (forceVal & forceMask);
  assign nextFlags   = txMode ? '0 : maskedFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outFlags <= '0;
    end else if (stb.latch) begin
      outFlags <= (sticky && !txMode) ? (outFlags | nextFlags) : nextFlags;
    end else if (stb.stickyClr) begin
      outFlags <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (stb.cntClr) begin
      errCount <= '0;
    end else if (stb.cntInc && errCount != CNT_MAX) begin
      errCount <= errCount + 1'b1;
    end
  end
endmodule

// File: rtl/edhFlagCtrl.sv
module edhFlagCtrl
  import edhFlagPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fieldEnd,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [2:0]           regAddr,
  input  logic [NUM_FLAG-1:0]  regWrData,
  input  logic [NUM_FLAG-1:0]  nextFlags,
  output strobe_t              stb,
  output logic [NUM_CLASS-1:0] userIdh,
  output logic [NUM_FLAG-1:0]  forceMask,
  output logic [NUM_FLAG-1:0]  forceVal,
  output logic                 sticky,
  output logic                 intN
);
  logic [NUM_FLAG-1:0] sensMask;
  logic autoClr;
  logic intActive;
  logic hit, flagRead, cntRead, clrCmd;

  assign hit      = |(nextFlags & sensMask);
  assign flagRead = regRdEn && (regAddr == ADDR_RD_FLAGS);
  assign cntRead  = regRdEn && (regAddr == ADDR_RD_CNT);
  assign clrCmd   = regWrEn && (regAddr == ADDR_CTRL) && regWrData[2];

  always_comb begin
    stb.latch     = fieldEnd;
    stb.cntInc    = fieldEnd & hit;
    stb.cntClr    = clrCmd | (cntRead & autoClr);
    stb.stickyClr = flagRead & sticky;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userIdh   <= '0;
      forceMask <= '0;
      forceVal  <= '0;
      sensMask  <= '1;
      sticky    <= 1'b0;
      autoClr   <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_IDH:   userIdh   <= regWrData[NUM_CLASS-1:0];
        ADDR_FMASK: forceMask <= regWrData;
        ADDR_FVAL:  forceVal  <= regWrData;
        ADDR_SENS:  sensMask  <= regWrData;
        ADDR_CTRL: begin
          sticky  <= regWrData[0];
          autoClr <= regWrData[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                intActive <= 1'b0;
    else if (fieldEnd && hit) intActive <= 1'b1;
    else if (flagRead)        intActive <= 1'b0;
  end

  assign intN = ~intActive;
endmodule

// File: rtl/edhFlagProc.sv
module edhFlagProc
  import edhFlagPkg::*;
#(
  parameter int CNT_W = 21,
  localparam int RD_W = (CNT_W > NUM_FLAG) ? CNT_W : NUM_FLAG
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fieldEnd,
  input  logic                txMode,
  input  logic                pktPresent,
  input  logic                crcValidAp,
  input  logic                crcValidFf,
  input  logic                crcErrAp,
  input  logic                crcErrFf,
  input  logic                ancSumErr,
  input  logic [NUM_FLAG-1:0] inFlags,
  input  logic [1:0]          dispSel,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [2:0]          regAddr,
  input  logic [NUM_FLAG-1:0] regWrData,
  output logic [RD_W-1:0]     regRdData,
  output logic [NUM_FLAG-1:0] outFlags,
  output logic                dispFl1,
  output logic                dispFl0,
  output logic                intN,
  output logic [CNT_W-1:0]    errCount
);
  strobe_t              stb;
  logic [NUM_CLASS-1:0] userIdh;
  logic [NUM_FLAG-1:0]  forceMask, forceVal, nextFlags;
  logic                 sticky;

  edhFlagCtrl uCtrl (
    .clk(clk), .rstN(rstN), .fieldEnd(fieldEnd),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .nextFlags(nextFlags), .stb(stb), .userIdh(userIdh),
    .forceMask(forceMask), .forceVal(forceVal), .sticky(sticky), .intN(intN)
  );

  edhFlagPath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .txMode(txMode), .pktPresent(pktPresent),
    .crcValidAp(crcValidAp), .crcValidFf(crcValidFf),
    .crcErrAp(crcErrAp), .crcErrFf(crcErrFf), .ancSumErr(ancSumErr),
    .inFlags(inFlags), .userIdh(userIdh), .forceMask(forceMask), .forceVal(forceVal),
    .sticky(sticky), .nextFlags(nextFlags), .outFlags(outFlags), .errCount(errCount)
  );

  always_comb begin
    case (regAddr)
      ADDR_RD_FLAGS: regRdData = RD_W'(outFlags);
      ADDR_RD_CNT:   regRdData = RD_W'(errCount);
      default:       regRdData = '0;
    endcase
  end

  always_comb begin
    case (dispSel)
      2'd0: {dispFl1, dispFl0} = {outFlags[C_FF*NUM_KIND + K_EDA],  outFlags[C_FF*NUM_KIND + K_EDH]};
      2'd1: {dispFl1, dispFl0} = {outFlags[C_AP*NUM_KIND + K_EDA],  outFlags[C_AP*NUM_KIND + K_EDH]};
      2'd2: {dispFl1, dispFl0} = {outFlags[C_ANC*NUM_KIND + K_EDA], outFlags[C_ANC*NUM_KIND + K_EDH]};
      default: begin
        dispFl1 = outFlags[C_AP*NUM_KIND + K_UES] | outFlags[C_FF*NUM_KIND + K_UES]
                | outFlags[C_ANC*NUM_KIND + K_UES];
        dispFl0 = outFlags[C_AP*NUM_KIND + K_IDA] | outFlags[C_FF*NUM_KIND + K_IDA]
                | outFlags[C_ANC*NUM_KIND + K_IDA];
      end
    endcase
  end
endmodule

// File: rtl/edhFlagChk.sv
module edhFlagChk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rstN,
  input logic             fieldEnd,
  input logic             txMode,
  input logic             regRdEn,
  input logic             intN,
  input logic [14:0]      outFlags,
  input logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r6_tx_clears: assert property (@(posedge clk) disable iff (!rstN)
    (fieldEnd && txMode) |=> (outFlags == '0));

  a_r7_hold_field: assert property (@(posedge clk) disable iff (!rstN)
    (!fieldEnd && !regRdEn) |=> $stable(outFlags));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |->
      (errCount == CNT_W'($past(errCount) + 1'b1) || errCount == '0));

  a_r8_count_at_field: assert property (@(posedge clk) disable iff (!rstN)
    (errCount > $past(errCount)) |-> $past(fieldEnd));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX) |=> (errCount == CNT_MAX || errCount == '0));

  a_r10_int_set: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(fieldEnd));

  a_r10_int_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> $past(regRdEn));
endmodule

bind edhFlagProc edhFlagChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .fieldEnd(fieldEnd), .txMode(txMode), .regRdEn(regRdEn),
  .intN(intN), .outFlags(outFlags), .errCount(errCount)
);

// File: tb/tb_edhFlagProc.sv
module tb_edhFlagProc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldEnd = 0, txMode = 0, pktPresent = 0, crcValidAp = 0, crcValidFf = 0;
  logic crcErrAp = 0, crcErrFf = 0, ancSumErr = 0;
  logic [14:0] inFlags = '0;
  logic [1:0]  dispSel = '0;
  logic regWrEn = 0, regRdEn = 0;
  logic [2:0]  regAddr = '0;
  logic [14:0] regWrData = '0;
  logic [20:0] regRdData;
  logic [14:0] outFlags;
  logic dispFl1, dispFl0, intN;
  logic [20:0] errCount;
  logic [14:0] sRdData, sFlags;
  logic sFl1, sFl0, sIntN;
  logic [2:0] sCount;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  edhFlagProc dut (
    .clk(clk), .rstN(rstN), .fieldEnd(fieldEnd), .txMode(txMode), .pktPresent(pktPresent),
    .crcValidAp(crcValidAp), .crcValidFf(crcValidFf), .crcErrAp(crcErrAp), .crcErrFf(crcErrFf),
    .ancSumErr(ancSumErr), .inFlags(inFlags), .dispSel(dispSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .outFlags(outFlags), .dispFl1(dispFl1), .dispFl0(dispFl0), .intN(intN), .errCount(errCount)
  );

  edhFlagProc #(.CNT_W(3)) dutSat (
    .clk(clk), .rstN(rstN), .fieldEnd(fieldEnd), .txMode(txMode), .pktPresent(pktPresent),
    .crcValidAp(crcValidAp), .crcValidFf(crcValidFf), .crcErrAp(crcErrAp), .crcErrFf(crcErrFf),
    .ancSumErr(ancSumErr), .inFlags(inFlags), .dispSel(dispSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(sRdData),
    .outFlags(sFlags), .dispFl1(sFl1), .dispFl0(sFl0), .intN(sIntN), .errCount(sCount)
  );

  // {pkt, validAp, validFf, errAp, errFf, errAnc, inFlags, expected outFlags}
  localparam int NVEC = 6;
  localparam logic [35:0] VEC [NVEC] = '{
    {6'b111000, 15'h0000, 15'h0000},
    {6'b111100, 15'h0001, 15'h0003},
    {6'b101000, 15'h0021, 15'h0040},
    {6'b111000, 15'h5504, 15'h6908},
    {6'b011101, 15'h7FFF, 15'h4610},
    {6'b100011, 15'h0202, 15'h0622}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setIn(input logic [5:0] ctl, input logic [14:0] f);
    {pktPresent, crcValidAp, crcValidFf, crcErrAp, crcErrFf, ancSumErr} = ctl;
    inFlags = f;
  endtask

  task automatic runField();
    @(negedge clk) fieldEnd = 1'b1;
    @(negedge clk) fieldEnd = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [14:0] d);
    @(negedge clk) begin regWrEn = 1'b1; regAddr = a; regWrData = d; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [20:0] d);
    @(negedge clk) begin regRdEn = 1'b1; regAddr = a; end
    #1 d = regRdData;
    @(negedge clk) regRdEn = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [20:0] rd;
    logic [20:0] cnt0;
    int expCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 flags", 32'(outFlags), 0);
    check("R11 count", 32'(errCount), 0);
    check("R11 intN", 32'(intN), 1);

    // R1 R2 R3 R8 vector table; default sensitivity all ones (R11)
    expCnt = 0;
    for (int i = 0; i < NVEC; i++) begin
      setIn(VEC[i][35:30], VEC[i][29:15]);
      runField();
      if (VEC[i][14:0] != 0) expCnt++;
      check($sformatf("R1/R2/R3 vector %0d", i), 32'(outFlags), 32'(VEC[i][14:0]));
    end
    check("R8 R11 count after vectors", 32'(errCount), 32'(expCnt));
    check("R10 int after errors", 32'(intN), 0);

    // R7 hold between field ends
    setIn(6'b111111, 15'h7FFF);
    repeat (3) @(negedge clk);
    check("R7 hold", 32'(outFlags), 32'h0622);

    // R12 display
    setIn(6'b111100, 15'h0001);
    runField();
    dispSel = 2'd1; #1 check("R12 sel1", 32'({dispFl1, dispFl0}), 32'b11);
    dispSel = 2'd0; #1 check("R12 sel0", 32'({dispFl1, dispFl0}), 32'b00);
    setIn(6'b000000, 15'h0000);
    runField();
    dispSel = 2'd3; #1 check("R12 sel3", 32'({dispFl1, dispFl0}), 32'b10);
    dispSel = 2'd2; #1 check("R12 sel2", 32'({dispFl1, dispFl0}), 32'b00);

    // R4 user IDH
    writeReg(3'd0, 15'b101);
    setIn(6'b111000, 15'h0000);
    runField();
    check("R4 idh", 32'(outFlags), 32'h1004);
    writeReg(3'd0, 15'h0);

    // R5 masking, R6 transmit
    writeReg(3'd1, 15'h0021);
    writeReg(3'd2, 15'h0001);
    setIn(6'b111011, 15'h0000);
    runField();
    check("R5 forced+transparent", 32'(outFlags), 32'h0401);
    txMode = 1'b1;
    runField();
    check("R6 tx clear", 32'(outFlags), 32'h0000);
    txMode = 1'b0;
    writeReg(3'd1, 15'h0);
    writeReg(3'd2, 15'h0);

    // R10 interrupt with narrowed sensitivity
    readReg(3'd0, rd);
    check("R10 released by read", 32'(intN), 1);
    writeReg(3'd3, 15'h0400);
    cnt0 = errCount;
    setIn(6'b111100, 15'h0001);
    runField();
    check("R10 insensitive int", 32'(intN), 1);
    check("R8 insensitive count", 32'(errCount), 32'(cnt0));
    setIn(6'b111001, 15'h0000);
    runField();
    check("R10 sensitive int", 32'(intN), 0);
    check("R8 sensitive count", 32'(errCount), 32'(cnt0 + 1));
    setIn(6'b111000, 15'h0000);
    runField();
    check("R10 held", 32'(intN), 0);
    readReg(3'd0, rd);
    check("R10 cleared", 32'(intN), 1);
    writeReg(3'd3, 15'h7FFF);

    // R13 sticky
    writeReg(3'd4, 15'b001);
    setIn(6'b111100, 15'h0001);
    runField();
    setIn(6'b111000, 15'h0000);
    runField();
    check("R13 sticky held", 32'(outFlags), 32'h0003);
    setIn(6'b111001, 15'h0000);
    runField();
    check("R13 sticky or", 32'(outFlags), 32'h0403);
    readReg(3'd0, rd);
    check("R13 read value", 32'(rd), 32'h0403);
    check("R13 read clears", 32'(outFlags), 0);
    writeReg(3'd4, 15'b000);

    // R8 clear command and auto-clear
    writeReg(3'd4, 15'b100);
    check("R8 clear cmd", 32'(errCount), 0);
    writeReg(3'd4, 15'b010);
    setIn(6'b111100, 15'h0001);
    runField();
    readReg(3'd1, rd);
    check("R8 autoclr read", 32'(rd), 1);
    check("R8 autoclr cleared", 32'(errCount), 0);
    writeReg(3'd4, 15'b000);

    // R9 saturation on the narrow instance
    writeReg(3'd4, 15'b100);
    for (int i = 0; i < 9; i++) runField();
    check("R9 wide count", 32'(errCount), 9);
    check("R9 narrow saturates", 32'(sCount), 7);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule